// File: doc/BRIEF.md
# Static Memory Turnaround-Insertion Sequencer

This block sits between a simple single-request port and a static memory bus. It steps each accepted access through an optional idle gap and then a data phase, during which the selected bank's chip-select is driven. The length of the gap depends on the access just finished and the one now accepted. Software-set per-bank fields give a data-phase length and a default gap length, but many combinations of the two accesses replace the programmed gap with a fixed count of 0, 1, 2 or 3 cycles. The inputs that decide this are read or write, synchronous or asynchronous, address/data multiplexed or not, and same bank or a different one.

A request is taken only while the sequencer is idle, so there is never more than one outstanding access. The block remembers the last completed access. When the next request is accepted, it works out the gap, holds all chip-selects low for that many cycles, and then runs the data phase. A one-cycle `done` pulse marks the final data-phase cycle. After reset no previous access is known, so the first access starts its data phase at once.

Top module: `smem_gap_seq`

## Requirements
- R1: `req_ready` is high exactly when the sequencer is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` stays low through every gap and data-phase cycle.
- R2: An asynchronous access has a data phase of F+1 cycles. F is its bank's 8-bit data field, `cfg_dlen[8*b +: 8]`. The reserved value F=0 is treated as F=1, giving 2 cycles.
- R3: A synchronous access ignores the data field, and its data phase lasts SYNC_DATA_CYC cycles (default 1).
- R4: During the data phase, only `mem_cs[b]` is high, where b is the access's bank number. All chip-selects are low while idle and during the gap.
- R5: `done` is high for exactly one cycle, which is the last data-phase cycle of each access.
- R6: The first access after reset gets a gap of 0 cycles.
- R7: An asynchronous write followed by an asynchronous write to the same bank gets a gap of 0 cycles when neither access is multiplexed.
- R8: After a non-multiplexed asynchronous read, the gap is 1 cycle when the next access is also non-multiplexed.
- R9: After a synchronous write, the gap is 2 cycles if the next access is asynchronous or is a synchronous write to the same bank. Otherwise it is 3 cycles.
- R10: After a synchronous read, the gap is 3 cycles if the next access targets a different bank and 0 cycles if it targets the same bank.
- R11: In every other case, the gap equals the previous access's bank turnaround field, `cfg_turn[4*b +: 4]` (0 to 15 cycles). This includes an asynchronous previous access where either access is multiplexed, and an asynchronous write followed by a write to another bank or by a read.
- R12: The gap cycles, with `turn_phase` high, start in the cycle right after acceptance. The data phase, with `data_phase` high, follows directly after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_bank | input | BANK_W | Target bank number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sync | input | 1 | 1 = synchronous access |
| req_mux | input | 1 | 1 = multiplexed address/data access |
| cfg_dlen | input | 8*NUM_BANKS | Per-bank data-phase field, bank b at bits 8*b+7:8*b |
| cfg_turn | input | 4*NUM_BANKS | Per-bank turnaround field, bank b at bits 4*b+3:4*b |
| req_ready | output | 1 | Sequencer idle, request can be accepted |
| mem_cs | output | NUM_BANKS | One-hot active-high chip-select |
| turn_phase | output | 1 | Idle gap in progress |
| data_phase | output | 1 | Data phase in progress |
| done | output | 1 | Last data-phase cycle of the access |

## Verification
Assertions check these properties on every cycle: chip-select stays one-hot and is silent during the gap and while idle, ready never overlaps an active phase, and the done pulse never lasts two cycles. They also check that the phase counter always counts down by one, that the history flag never clears once set, and that the fixed-gap classes (first access, async read, sync write) produce their allowed counts. The exact gap length for every pair of accesses, the data-phase length from the per-bank fields, and the position of the done pulse can only be seen in the bench's scenarios. The bench compares each of these against its own model of the access history.

// File: rtl/smem_seq_pkg.sv
package smem_seq_pkg;

  localparam int TURN_W     = 4;
  localparam int DLEN_W     = 8;
  localparam int CNT_W      = DLEN_W + 1;
  localparam int BANK_IDX_W = 4;

  typedef struct packed {
    logic                  wr;
    logic                  sync;
    logic                  mux;
    logic [BANK_IDX_W-1:0] bank;
  } acc_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TURN = 2'd1,
    ST_DATA = 2'd2
  } seq_st_e;

  // Idle cycles to insert between previous access p and next access n.
  function automatic logic [TURN_W-1:0] gap_pick(
    input logic              pv,
    input acc_t              p,
    input acc_t              n,
    input logic [TURN_W-1:0] prog
  );
    logic same;
    same = (p.bank == n.bank);
    if (!pv) return '0;
    if (p.sync) begin
      if (p.wr) return (!n.sync || (n.wr && same)) ? TURN_W'(2) : TURN_W'(3);
      return same ? '0 : TURN_W'(3);
    end
    if (p.mux || n.mux) return prog;
    if (!p.wr) return TURN_W'(1);
    if (n.wr && !n.sync && same) return '0;
    return prog;
  endfunction

  // Data-phase length in cycles.
  function automatic logic [CNT_W-1:0] data_cycles(
    input logic              sync,
    input logic [DLEN_W-1:0] field,
    input logic [CNT_W-1:0]  sync_cyc
  );
    if (sync) return sync_cyc;
    if (field == '0) return CNT_W'(2);
    return CNT_W'(field) + CNT_W'(1);
  endfunction

endpackage

// File: rtl/smem_gap_rule.sv
module smem_gap_rule
  import smem_seq_pkg::*;
(
  input  logic              prev_valid,
  input  acc_t              prev_acc,
  input  acc_t              next_acc,
  input  logic [TURN_W-1:0] prog_turn,
  output logic [TURN_W-1:0] gap,
  output logic              gap_is_prog
);

  always_comb begin
    gap         = gap_pick(prev_valid, prev_acc, next_acc, prog_turn);
    gap_is_prog = prev_valid && !prev_acc.sync &&
                  (prev_acc.mux || next_acc.mux ||
                   (prev_acc.wr && !(next_acc.wr && !next_acc.sync &&
                                     prev_acc.bank == next_acc.bank)));
  end

endmodule

// File: rtl/smem_phase_cnt.sv
module smem_phase_cnt #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         zero
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (dec)   cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);

  // R12
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && !zero) |=> (cnt == $past(cnt) - W'(1)));

endmodule

// File: rtl/smem_hist.sv
module smem_hist
  import smem_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  acc_t cur_acc,
  output acc_t prev_acc,
  output logic prev_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_acc   <= '0;
      prev_valid <= 1'b0;
    end else if (commit) begin
      prev_acc   <= cur_acc;
      prev_valid <= 1'b1;
    end
  end

  // R6
  hist_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(prev_valid));

endmodule

// File: rtl/smem_gap_seq.sv
module smem_gap_seq
  import smem_seq_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int SYNC_DATA_CYC = 1,
  localparam int BANK_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [BANK_W-1:0]           req_bank,
  input  logic                        req_write,
  input  logic                        req_sync,
  input  logic                        req_mux,
  input  logic [NUM_BANKS*DLEN_W-1:0] cfg_dlen,
  input  logic [NUM_BANKS*TURN_W-1:0] cfg_turn,
  output logic                        req_ready,
  output logic [NUM_BANKS-1:0]        mem_cs,
  output logic                        turn_phase,
  output logic                        data_phase,
  output logic                        done
);

  seq_st_e           st;
  acc_t              cur_q, nxt_acc, prev_acc;
  logic              prev_valid;
  logic [CNT_W-1:0]  dlen_q, dlen_new, cnt, cnt_ld_val;
  logic              cnt_zero, cnt_ld, cnt_dec;
  logic [TURN_W-1:0] prog_turn, gap;
  logic [DLEN_W-1:0] req_field;
  logic              gap_is_prog;
  logic              accept;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    nxt_acc      = '0;
    nxt_acc.wr   = req_write;
    nxt_acc.sync = req_sync;
    nxt_acc.mux  = req_mux;
    nxt_acc.bank = BANK_IDX_W'(req_bank);
  end

  // Per-bank field selection.
  always_comb begin
    prog_turn = '0;
    req_field = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (prev_acc.bank == BANK_IDX_W'(b)) prog_turn = cfg_turn[b*TURN_W +: TURN_W];
      if (nxt_acc.bank == BANK_IDX_W'(b))  req_field = cfg_dlen[b*DLEN_W +: DLEN_W];
    end
    dlen_new = data_cycles(req_sync, req_field, CNT_W'(SYNC_DATA_CYC));
  end

  smem_gap_rule u_rule (
    .prev_valid  (prev_valid),
    .prev_acc    (prev_acc),
    .next_acc    (nxt_acc),
    .prog_turn   (prog_turn),
    .gap         (gap),
    .gap_is_prog (gap_is_prog)
  );

  smem_hist u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (done),
    .cur_acc    (cur_q),
    .prev_acc   (prev_acc),
    .prev_valid (prev_valid)
  );

  always_comb begin
    cnt_ld     = accept || (st == ST_TURN && cnt_zero);
    if (accept)
      cnt_ld_val = (gap != '0) ? CNT_W'(gap) - CNT_W'(1) : dlen_new - CNT_W'(1);
    else
      cnt_ld_val = dlen_q - CNT_W'(1);
    cnt_dec    = (st != ST_IDLE) && !cnt_zero;
  end

  smem_phase_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_ld),
    .load_val (cnt_ld_val),
    .dec      (cnt_dec),
    .cnt      (cnt),
    .zero     (cnt_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cur_q  <= '0;
      dlen_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          cur_q  <= nxt_acc;
          dlen_q <= dlen_new;
          st     <= (gap != '0) ? ST_TURN : ST_DATA;
        end
        ST_TURN: if (cnt_zero) st <= ST_DATA;
        ST_DATA: if (cnt_zero) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign turn_phase = (st == ST_TURN);
  assign data_phase = (st == ST_DATA);
  assign done       = data_phase && cnt_zero;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
    assign mem_cs[b] = data_phase && (cur_q.bank == BANK_IDX_W'(b));
  end

  // R4
  cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (turn_phase || req_ready) |-> (mem_cs == '0));
  // R4
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_cs));
  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!turn_phase && !data_phase));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  first_nogap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !prev_valid) |=> data_phase);
  // R8
  aread_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && prev_valid && !prev_acc.sync && !prev_acc.wr && !prev_acc.mux && !req_mux)
      |-> (gap == TURN_W'(1)));
  // R9
  swrite_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && prev_valid && prev_acc.sync && prev_acc.wr)
      |-> (gap == TURN_W'(2) || gap == TURN_W'(3)));
  // R11
  prog_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && gap_is_prog) |-> (gap == prog_turn));

endmodule

// File: tb/smem_gap_seq_tb.sv
module smem_gap_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NB         = 4;
  localparam int BW         = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic [BW-1:0]   req_bank = '0;
  logic            req_write = 1'b0, req_sync = 1'b0, req_mux = 1'b0;
  logic [NB*8-1:0] cfg_dlen = '0;
  logic [NB*4-1:0] cfg_turn = '0;
  logic            req_ready, turn_phase, data_phase, done;
  logic [NB-1:0]   mem_cs;

  int n_vec = 0;
  int n_bad = 0;

  // bench model of history
  logic          m_pv = 1'b0;
  logic [BW-1:0] m_bank;
  logic          m_wr, m_sync, m_mux;

  always #(CLK_PERIOD/2) clk = ~clk;

  smem_gap_seq #(.NUM_BANKS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_write(req_write), .req_sync(req_sync), .req_mux(req_mux),
    .cfg_dlen(cfg_dlen), .cfg_turn(cfg_turn), .req_ready(req_ready),
    .mem_cs(mem_cs), .turn_phase(turn_phase), .data_phase(data_phase), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_gap(input logic [BW-1:0] bank, input logic wr,
                                 input logic sy, input logic mx);
    int prog;
    prog = int'(cfg_turn[m_bank*4 +: 4]);
    if (!m_pv) return 0;                                   // R6
    case ({m_sync, m_wr})
      2'b11: begin                                         // R9
        if (sy && !(wr && bank == m_bank)) return 3;
        return 2;
      end
      2'b10: return (bank != m_bank) ? 3 : 0;              // R10
      default: begin
        if (m_mux || mx) return prog;                      // R11
        if (m_wr == 1'b0) return 1;                        // R8
        if (wr && !sy && bank == m_bank) return 0;         // R7
        return prog;                                       // R11
      end
    endcase
  endfunction

  function automatic int exp_dlen(input logic [BW-1:0] bank, input logic sy);
    int f;
    if (sy) return 1;                                      // R3
    f = int'(cfg_dlen[bank*8 +: 8]);
    return (f < 1 ? 1 : f) + 1;                            // R2
  endfunction

  task automatic do_access(input logic [BW-1:0] bank, input logic wr,
                           input logic sy, input logic mx, input string tag);
    int eg, ed, t, d, done_at, done_n;
    bit cs_ok, rdy_ok;
    while (!req_ready) @(negedge clk);
    eg = exp_gap(bank, wr, sy, mx);
    ed = exp_dlen(bank, sy);
    req_bank = bank; req_write = wr; req_sync = sy; req_mux = mx; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    t = 0; d = 0; done_at = -1; done_n = 0; cs_ok = 1; rdy_ok = 1;
    while (turn_phase) begin
      if (mem_cs != '0) cs_ok = 0;
      if (req_ready) rdy_ok = 0;
      t++;
      @(negedge clk);
    end
    while (data_phase) begin
      if (mem_cs != NB'(1) << bank) cs_ok = 0;
      if (req_ready) rdy_ok = 0;
      if (done) begin done_n++; done_at = d; end
      d++;
      @(negedge clk);
    end
    chk(t == eg, {"R12 gap ", tag}, t, eg);
    chk(d == ed, "R2/R3 data length", d, ed);
    chk(cs_ok, "R4 chip-select", int'(cs_ok), 1);
    chk(rdy_ok && req_ready, "R1 ready", int'(rdy_ok && req_ready), 1);
    chk(done_n == 1 && done_at == d - 1, "R5 done position", done_at, d - 1);
    m_pv = 1'b1; m_bank = bank; m_wr = wr; m_sync = sy; m_mux = mx;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    cfg_dlen = {8'd3, 8'd0, 8'd5, 8'd1};
    cfg_turn = {4'd9, 4'd0, 4'd15, 4'd7};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    chk(mem_cs == '0 && !turn_phase && !data_phase && !done, "R4 reset idle",
        int'(mem_cs), 0);

    do_access(2'd0, 1, 0, 0, "R6 first");
    do_access(2'd0, 1, 0, 0, "R7 awr-awr same");
    do_access(2'd1, 1, 0, 0, "R11 awr other bank");
    do_access(2'd1, 0, 0, 0, "R11 awr-ard");
    do_access(2'd1, 0, 0, 0, "R8 ard same");
    do_access(2'd2, 1, 1, 0, "R8 ard-swr");
    do_access(2'd2, 1, 1, 0, "R9 swr same");
    do_access(2'd3, 1, 1, 0, "R9 swr other");
    do_access(2'd3, 0, 1, 0, "R9 swr-srd");
    do_access(2'd3, 0, 1, 0, "R10 srd same");
    do_access(2'd0, 0, 0, 1, "R10 srd other");
    do_access(2'd0, 1, 0, 1, "R11 mux");
    do_access(2'd2, 1, 1, 0, "R11 mux-swr");
    do_access(2'd2, 0, 0, 0, "R9 swr-async");

    for (int i = 0; i < 400; i++) begin
      for (int b = 0; b < NB; b++) begin
        cfg_turn[b*4 +: 4] = 4'($urandom_range(0, 15));
        case ($urandom_range(0, 9))
          0:       cfg_dlen[b*8 +: 8] = 8'd0;
          1:       cfg_dlen[b*8 +: 8] = 8'd255;
          default: cfg_dlen[b*8 +: 8] = 8'($urandom_range(1, 12));
        endcase
      end
      do_access(BW'($urandom_range(0, NB-1)), 1'($urandom), 1'($urandom),
                1'($urandom_range(0, 3) == 0), "random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule